// File: doc/BRIEF.md
# HDLC Frame Status Queue

This block sits on the receive side of a bit-oriented HDLC/SDLC receiver. It counts the data bytes that arrive between flags and, whenever a frame closes, stores that byte count together with the frame's status bits as one queue entry. The host can therefore pick up the length and outcome of several back-to-back frames some time after they arrive, without racing the receiver.

The host reads three registers in a fixed order. The first register holds the queue flags and the high part of the count. The second, which is optional, holds the low eight count bits. The third holds the frame status, and reading it retires the entry. The first read freezes the "entry present" state, and that frozen state picks the source of the two reads that follow. If the queue was empty, those reads return the live counter and the live receiver status. A status read retires at most one entry per sequence, so repeated status reads can neither drain the queue nor underflow it. Clearing the enable control input resets the whole queue, including the sticky overflow indication.

Top module: `sfs_frame_status_fifo`

## Requirements
- R1: `flag_seen` clears the live byte counter to 0. Each `byte_stb` adds one. When both occur in the same cycle, the clear wins. A flag alone never creates a queue entry.
- R2: The live byte counter saturates at 2^CNT_W-1 (16383 by default) and holds there while further strobes arrive.
- R3: When `fifo_en` is high, an `eof` pulse stores the live count and `live_status` as one entry. Entries come back out in arrival order. An `eof` while `fifo_en` is low stores nothing.
- R4: The host registers are selected by `rd_sel`: 0 = flags, 1 = low count, 2 = status, 3 = reads as 0. The flags byte is laid out as follows:
  - bit 7: overflow.
  - bit 6: at least one entry is queued at the time of this read.
  - bits 5:0: count bits 13:8, taken from the oldest entry, or from the live counter when the queue is empty.
- R5: A flags read latches bit 6. After it, the low-count read returns count bits 7:0 and the status read returns `{3'b000, status}`. Both come from the oldest entry if the latched bit was 1, and otherwise from the live counter and `live_status`. Before any flags read, these two reads return the live values.
- R6: A status read retires exactly one entry per flags read. Further status reads return `live_status` and leave the queue unchanged.
- R7: Status reads while the queue is empty leave it intact. A frame pushed afterwards is read back correctly and the queue then reports empty again.
- R8: With DEPTH (10) entries held, a further `eof` sets the overflow bit and is dropped. The held entries stay unchanged.
- R9: The overflow bit stays set through reads. Only holding `fifo_en` low clears it and empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Queue enable; low holds the queue cleared |
| flag_seen | input | 1 | Flag detected pulse; clears the byte counter |
| byte_stb | input | 1 | Received data byte strobe |
| eof | input | 1 | End-of-frame pulse |
| live_status | input | 5 | Current frame status: {end, crc error, overrun, residue[1:0]} |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| rd_sel | input | 2 | Host register select |
| rd_data | output | 8 | Read data, valid in the cycle `rd_en` is high |

## Verification
A table of six frames, with lengths from zero to beyond 255 and distinct status codes, is queued in full and then drained. This separates order errors from high/low count-field mixups. Read patterns with doubled and tripled status reads, and status reads on an empty queue, tell a correct single-retire latch apart from one that pops on every read or wraps its pointers. An eleven-frame burst and an enable toggle separate drop-on-full from overwrite and show the overflow bit's lifetime. A long strobe run exposes counter wrap against saturation.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  // Host register selection codes
  typedef enum logic [1:0] {
    SEL_FLAGS  = 2'd0,
    SEL_CNT_LO = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } host_sel_e;

  // Saturating increment: stays at lim once reached
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Circular pointer advance over depth slots
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/sfs_byte_counter.sv
module sfs_byte_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_seen,
  input  logic             byte_stb,
  output logic [CNT_W-1:0] count
);
  import sfs_pkg::*;

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (flag_seen)
      count <= '0;
    else if (byte_stb)
      count <= CNT_W'(sat_inc(32'(count), CNT_MAX));
  end

endmodule

// File: rtl/sfs_entry_fifo.sv
module sfs_entry_fifo #(
  parameter int DEPTH   = 10,
  parameter int ENTRY_W = 19
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push_req,
  input  logic [ENTRY_W-1:0]           wr_entry,
  input  logic                         pop_req,
  output logic [ENTRY_W-1:0]           rd_entry,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         empty,
  output logic                         ovf,
  output logic                         push_ok,
  output logic                         push_drop
);
  import sfs_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic               full, pop_ok;

  assign empty     = (occ == '0);
  assign full      = (occ == OCC_W'(DEPTH));
  assign push_ok   = push_req & ~full;
  assign push_drop = push_req & full;
  assign pop_ok    = pop_req & ~empty;
  assign rd_entry  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clr)
      mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      ovf    <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok)
        wr_ptr <= PTR_W'(ptr_next(32'(wr_ptr), DEPTH));
      if (pop_ok)
        rd_ptr <= PTR_W'(ptr_next(32'(rd_ptr), DEPTH));
      if (push_ok && !pop_ok)
        occ <= occ + 1'b1;
      else if (pop_ok && !push_ok)
        occ <= occ - 1'b1;
      if (push_drop)
        ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/sfs_host_port.sv
module sfs_host_port #(
  parameter int CNT_W  = 14,
  parameter int STAT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  input  logic              empty,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  head_cnt,
  input  logic [STAT_W-1:0] head_stat,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic [STAT_W-1:0] live_stat,
  output logic [7:0]        rd_data,
  output logic              pop_fire,
  output logic              lat_fifo,
  output logic              armed
);
  import sfs_pkg::*;

  localparam int UP_W = CNT_W - 8;

  host_sel_e          sel;
  logic               fifo_now;
  logic [CNT_W-1:0]   up_src, lo_src;
  logic [STAT_W-1:0]  st_src;
  logic [5:0]         up6;

  assign sel      = host_sel_e'(rd_sel);
  assign fifo_now = ~empty;
  assign up_src   = fifo_now ? head_cnt : live_cnt;
  assign lo_src   = lat_fifo ? head_cnt : live_cnt;
  assign st_src   = lat_fifo ? head_stat : live_stat;
  assign up6      = 6'(up_src[CNT_W-1 -: UP_W]);
  assign pop_fire = rd_en & (sel == SEL_STATUS) & armed & lat_fifo;

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (sel)
        SEL_FLAGS:  rd_data = {ovf, fifo_now, up6};
        SEL_CNT_LO: rd_data = lo_src[7:0];
        SEL_STATUS: rd_data = 8'(st_src);
        default:    rd_data = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_fifo <= 1'b0;
      armed    <= 1'b0;
    end else if (clr) begin
      lat_fifo <= 1'b0;
      armed    <= 1'b0;
    end else if (rd_en) begin
      if (sel == SEL_FLAGS) begin
        lat_fifo <= fifo_now;
        armed    <= 1'b1;
      end else if (sel == SEL_STATUS) begin
        lat_fifo <= 1'b0;
        armed    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sfs_frame_status_fifo.sv
module sfs_frame_status_fifo #(
  parameter int DEPTH  = 10,
  parameter int CNT_W  = 14,
  parameter int STAT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              flag_seen,
  input  logic              byte_stb,
  input  logic              eof,
  input  logic [STAT_W-1:0] live_status,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  output logic [7:0]        rd_data
);
  localparam int ENTRY_W = STAT_W + CNT_W;
  localparam int OCC_W   = $clog2(DEPTH + 1);

  // Internal events brought out for the checker
  logic [CNT_W-1:0]   live_cnt;
  logic [ENTRY_W-1:0] head_entry;
  logic [OCC_W-1:0]   occ;
  logic               q_empty, ovf, push_ok, push_drop;
  logic               pop_fire, lat_fifo, armed, clr;

  assign clr = ~fifo_en;

  sfs_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_seen (flag_seen),
    .byte_stb  (byte_stb),
    .count     (live_cnt)
  );

  sfs_entry_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .push_req  (eof & fifo_en),
    .wr_entry  ({live_status, live_cnt}),
    .pop_req   (pop_fire),
    .rd_entry  (head_entry),
    .occ       (occ),
    .empty     (q_empty),
    .ovf       (ovf),
    .push_ok   (push_ok),
    .push_drop (push_drop)
  );

  sfs_host_port #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .empty     (q_empty),
    .ovf       (ovf),
    .head_cnt  (head_entry[CNT_W-1:0]),
    .head_stat (head_entry[ENTRY_W-1:CNT_W]),
    .live_cnt  (live_cnt),
    .live_stat (live_status),
    .rd_data   (rd_data),
    .pop_fire  (pop_fire),
    .lat_fifo  (lat_fifo),
    .armed     (armed)
  );

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int DEPTH = 10,
  parameter int CNT_W = 14
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fifo_en,
  input logic                       flag_seen,
  input logic                       byte_stb,
  input logic                       eof,
  input logic                       rd_en,
  input logic [1:0]                 rd_sel,
  input logic [CNT_W-1:0]           live_cnt,
  input logic [$clog2(DEPTH+1)-1:0] occ,
  input logic                       ovf,
  input logic                       pop_fire,
  input logic                       push_ok
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic stat_rd;
  assign stat_rd = rd_en && (rd_sel == 2'd2);

  assert_flag_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flag_seen |=> (live_cnt == '0));

  assert_byte_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !flag_seen && live_cnt != CMAX) |=> (live_cnt == $past(live_cnt) + 1'b1));

  assert_cnt_hold_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == CMAX && !flag_seen) |=> (live_cnt == CMAX));

  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_fire && fifo_en) |=> (occ == $past(occ) + 1'b1));

  assert_no_push_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !fifo_en) |-> !push_ok);

  assert_single_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && $past(stat_rd)) |-> !pop_fire);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> (occ != '0));

  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  assert_full_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && fifo_en && occ == OCC_W'(DEPTH)) |=> ovf);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && fifo_en) |=> ovf);

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (occ == '0 && !ovf));

endmodule

bind sfs_frame_status_fifo sfs_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fifo_en   (fifo_en),
  .flag_seen (flag_seen),
  .byte_stb  (byte_stb),
  .eof       (eof),
  .rd_en     (rd_en),
  .rd_sel    (rd_sel),
  .live_cnt  (live_cnt),
  .occ       (occ),
  .ovf       (ovf),
  .pop_fire  (pop_fire),
  .push_ok   (push_ok)
);

// File: tb/sfs_frame_status_fifo_tb.sv
module sfs_frame_status_fifo_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic       flag_seen = 1'b0;
  logic       byte_stb = 1'b0;
  logic       eof = 1'b0;
  logic [4:0] live_status = 5'h00;
  logic       rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd3;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sfs_frame_status_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flag_seen(flag_seen),
    .byte_stb(byte_stb), .eof(eof), .live_status(live_status),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  localparam int NV = 6;
  localparam int VEC_N [NV] = '{0, 1, 7, 255, 256, 1000};
  localparam logic [4:0] VEC_S [NV] = '{5'h10, 5'h18, 5'h14, 5'h13, 5'h11, 5'h1F};

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic pulse_flag();
    @(negedge clk) flag_seen = 1'b1;
    @(negedge clk) flag_seen = 1'b0;
  endtask

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) byte_stb = 1'b1;
    end
    @(negedge clk) byte_stb = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [4:0] st);
    pulse_flag();
    send_bytes(n);
    @(negedge clk) begin live_status = st; eof = 1'b1; end
    @(negedge clk) eof = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk) begin rd_en = 1'b1; rd_sel = sel; end
    #4 d = rd_data;
    @(negedge clk) rd_en = 1'b0;
  endtask

  // Full sequence expecting a queued entry with count c and status st
  task automatic read_entry(input string req, input int c, input logic [4:0] st, input bit ov);
    logic [7:0] d;
    host_read(2'd0, d);
    check(req, d, {ov, 1'b1, 6'((c >> 8) & 6'h3F)});
    host_read(2'd1, d);
    check(req, d, c & 8'hFF);
    host_read(2'd2, d);
    check(req, d, {3'b000, st});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state: empty, no overflow, live values (R4, R5)
    live_status = 5'h0A;
    host_read(2'd1, d); check("R5 pre-seq low count", d, 8'h00);
    host_read(2'd2, d); check("R5 pre-seq status", d, 8'h0A);
    host_read(2'd0, d); check("R4 reset flags", d, 8'h00);
    host_read(2'd3, d); check("R4 unused select", d, 8'h00);

    // Byte counter basics (R1)
    pulse_flag();
    send_bytes(3);
    host_read(2'd0, d); check("R1 flag makes no entry", d, 8'h00);
    host_read(2'd1, d); check("R1 live count 3", d, 8'h03);
    @(negedge clk) begin flag_seen = 1'b1; byte_stb = 1'b1; end
    @(negedge clk) begin flag_seen = 1'b0; byte_stb = 1'b0; end
    host_read(2'd0, d);
    host_read(2'd1, d); check("R1 flag beats strobe", d, 8'h00);

    // Vector table: queue all, drain in order (R3, R4, R5, R6)
    for (int i = 0; i < NV; i++) send_frame(VEC_N[i], VEC_S[i]);
    live_status = 5'h05;
    for (int i = 0; i < NV; i++) read_entry("R3 table entry", VEC_N[i], VEC_S[i], 1'b0);
    host_read(2'd0, d); check("R4 drained flags live upper", d, 8'h03);
    host_read(2'd1, d); check("R5 drained live low count", d, 8'hE8);
    host_read(2'd2, d); check("R5 drained live status", d, 8'h05);

    // Repeated status reads retire one entry only (R6)
    send_frame(5, 5'h10);
    send_frame(9, 5'h12);
    live_status = 5'h03;
    host_read(2'd0, d); check("R6 flags present", d, 8'h40);
    host_read(2'd2, d); check("R6 first status pops", d, 8'h10);
    host_read(2'd2, d); check("R6 second status live", d, 8'h03);
    host_read(2'd2, d); check("R6 third status live", d, 8'h03);
    read_entry("R6 second entry kept", 9, 5'h12, 1'b0);
    host_read(2'd0, d); check("R6 now empty", d, 8'h00);

    // Status reads on empty queue (R7)
    host_read(2'd2, d);
    host_read(2'd2, d);
    host_read(2'd0, d);
    host_read(2'd2, d); check("R7 empty status live", d, 8'h03);
    send_frame(4, 5'h11);
    read_entry("R7 entry after empty reads", 4, 5'h11, 1'b0);
    host_read(2'd0, d); check("R7 empty again", d, 8'h00);

    // EOF ignored while disabled (R3)
    @(negedge clk) fifo_en = 1'b0;
    send_frame(2, 5'h10);
    @(negedge clk) fifo_en = 1'b1;
    host_read(2'd0, d); check("R3 disabled eof dropped", d, 8'h00);

    // Overflow on eleventh frame (R8, R9)
    for (int i = 0; i < 11; i++) send_frame(i + 1, 5'h10);
    for (int i = 0; i < 10; i++) read_entry("R8 held entry", i + 1, 5'h10, 1'b1);
    host_read(2'd0, d); check("R9 overflow sticky after drain", d, 8'h80);
    @(negedge clk) fifo_en = 1'b0;
    @(negedge clk) fifo_en = 1'b1;
    host_read(2'd0, d); check("R9 overflow cleared by enable", d, 8'h00);
    send_frame(3, 5'h10);
    send_frame(3, 5'h10);
    @(negedge clk) fifo_en = 1'b0;
    @(negedge clk) fifo_en = 1'b1;
    host_read(2'd0, d); check("R9 contents cleared by enable", d, 8'h00);

    // Saturation (R2)
    pulse_flag();
    send_bytes(16390);
    host_read(2'd0, d); check("R2 saturated upper", d, 8'h3F);
    host_read(2'd1, d); check("R2 saturated low", d, 8'hFF);
    send_bytes(1);
    host_read(2'd0, d); check("R2 holds at max", d, 8'h3F);
    host_read(2'd1, d); check("R2 holds at max low", d, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule